// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block picks one interrupt out of ten vectored request lines and presents it to a processor. Software assigns every line one of three priority levels, low, high or top, through a level-configuration register. A line competes only while its own enable bit, its pending bit and the global interrupt enable are all set.

Among the competing lines the one with the highest level wins. Between lines of equal level, the one with the smaller vector address wins. The winner is offered to the processor only if its level is strictly above the level now in service. The block keeps that service level on a small stack. An accepted interrupt pushes its level, and a return-from-interrupt pulse pops it. Because of this, a handler can be preempted only by a request of a strictly higher level, and nested handlers unwind in order.

The processor answers a raised request with a take pulse. On the following clock the block gives a one-cycle acknowledge that carries the vector address and the accepted level. Vector addresses start at 0x00003, and each higher line index adds 0x8.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `irq_req` and `ack_valid` are 0, `cur_lvl` is 0 (nothing in service), and every line's level is low.
- R2: An acknowledge for line i carries `ack_vec` = 0x00003 + 8*i, so line 0 gives 0x00003 and line 9 gives 0x0004B.
- R3: Writing `cfg_we` loads every line's level from `cfg_wdata[2i+1:2i]`: 00 is low, 01 is high, and 10 or 11 is top. Levels are reported as 1 for low, 2 for high, 3 for top and 0 for none. A write takes effect from the next clock.
- R4: A line competes only while `src_en[i]`, `src_pend[i]` and `gie` are all 1. Otherwise it never causes a request or an acknowledge.
- R5: Among competing lines, the line with the highest level wins.
- R6: Among competing lines of the same top level, the line with the smallest index wins.
- R7: The winner qualifies only if its level is strictly above `cur_lvl`. A winner of equal or lower level gives no request and no acknowledge.
- R8: `irq_req` is registered. In each cycle it shows whether a winner qualified in the previous cycle.
- R9: `irq_take` in a cycle where a winner qualifies produces, on the next clock, `ack_valid` high for one cycle with `ack_vec` and `ack_lvl`. The level is pushed at the same time, so `cur_lvl` becomes `ack_lvl`.
- R10: A `reti` pulse pops one level, which restores the previous `cur_lvl`. A `reti` on an empty stack has no effect. When `reti` and `irq_take` fall in the same cycle, only the pop happens.
- R11: While the level stack holds `STACK_DEPTH` entries, no winner qualifies, so there is no request and `irq_take` is ignored. This lasts until a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie | input | 1 | Global interrupt enable |
| src_en | input | N_SRC | Per-line enable |
| src_pend | input | N_SRC | Per-line pending flag |
| cfg_we | input | 1 | Level-configuration write strobe |
| cfg_wdata | input | 2*N_SRC | Level codes, two bits per line |
| irq_take | input | 1 | Processor takes the offered interrupt |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Registered request to the processor |
| ack_valid | output | 1 | One-cycle acknowledge strobe |
| ack_vec | output | ADDR_W | Vector address of the acknowledged line |
| ack_lvl | output | 2 | Level of the acknowledged line |
| cur_lvl | output | 2 | Level now in service (0 means none) |

## Verification
The bench targets the following corner cases, with the failure each one exposes:
- **Equal-level contender:** a request at the same level as the handler already in service must not preempt it. A design that compares with "greater or equal" would re-enter the running handler.
- **Tie between lines:** when lines of one level tie, a scan in the wrong direction would hand out the larger vector address.
- **Pop on an empty stack, and a pop that lands together with a take:** a stack pointer that is not guarded would underflow and corrupt `cur_lvl`, or would accept an interrupt that should have been dropped.
- **Full stack:** with the stack filled, a top-level request must stay blocked until a return. A design that lets it through would lose a saved level.

A long random phase, checked every clock against a behavioural model, mixes level rewrites, gating and nesting.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } irq_lvl_e;

  // Map a two-bit software level code onto the internal ordered level.
  function automatic irq_lvl_e code_to_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b01:   return LVL_HIGH;
      default: return LVL_TOP;
    endcase
  endfunction

endpackage

// File: rtl/irqa_lvl_cfg.sv
module irqa_lvl_cfg
  import irqa_pkg::*;
#(
  parameter int N_SRC = 10,
  localparam int CFG_W = 2 * N_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] lvl_flat
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    irq_lvl_e lvl_q;

    always_ff @(posedge clk) begin
      if (rst)     lvl_q <= LVL_LOW;
      else if (we) lvl_q <= code_to_lvl(wdata[2*g +: 2]);
    end

    assign lvl_flat[2*g +: 2] = lvl_q;
  end

endmodule

// File: rtl/irqa_pick.sv
module irqa_pick #(
  parameter int N_SRC = 10,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]   cand,
  input  logic [2*N_SRC-1:0] lvl_flat,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic [1:0]         win_lvl
);

  logic [1:0] lvl_arr [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_split
    assign lvl_arr[g] = lvl_flat[2*g +: 2];
  end

  // Scan from the highest index down. A later (lower-index) line replaces
  // the current best when its level is equal or higher, so among equal
  // levels the lowest index remains.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = 2'd0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (lvl_arr[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl_arr[i];
      end
    end
  end

endmodule

// File: rtl/irqa_lvl_stack.sv
module irqa_lvl_stack #(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [1:0] push_lvl,
  input  logic       pop,
  output logic [1:0] top_lvl,
  output logic       full,
  output logic       empty
);

  logic [1:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign cnt_m1 = cnt - CNT_W'(1);

  // Storage carries no reset; only the fill count does.
  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PTR_W-1:0]] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (pop && !empty)  cnt <= cnt_m1;
    else if (push && !full)  cnt <= cnt + CNT_W'(1);
  end

  assign top_lvl = empty ? 2'd0 : mem[cnt_m1[PTR_W-1:0]];

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int N_SRC       = 10,
  parameter int STACK_DEPTH = 3,
  parameter int ADDR_W      = 20,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CFG_W = 2 * N_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gie,
  input  logic [N_SRC-1:0]  src_en,
  input  logic [N_SRC-1:0]  src_pend,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              irq_take,
  input  logic              reti,
  output logic              irq_req,
  output logic              ack_valid,
  output logic [ADDR_W-1:0] ack_vec,
  output logic [1:0]        ack_lvl,
  output logic [1:0]        cur_lvl
);

  logic [CFG_W-1:0] lvl_flat;
  logic [N_SRC-1:0] cand;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       win_lvl;
  logic             stk_full;
  logic             stk_empty;
  logic             qualify;
  logic             accept;
  logic             pop;

  irqa_lvl_cfg #(.N_SRC(N_SRC)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .lvl_flat (lvl_flat)
  );

  assign cand = gie ? (src_en & src_pend) : '0;

  irqa_pick #(.N_SRC(N_SRC)) u_pick (
    .cand      (cand),
    .lvl_flat  (lvl_flat),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign qualify = win_valid && (win_lvl > cur_lvl) && !stk_full;
  assign pop     = reti && !stk_empty;
  assign accept  = irq_take && qualify && !reti;

  irqa_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (accept),
    .push_lvl (win_lvl),
    .pop      (pop),
    .top_lvl  (cur_lvl),
    .full     (stk_full),
    .empty    (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      ack_valid <= 1'b0;
      ack_vec   <= '0;
      ack_lvl   <= 2'd0;
    end else begin
      irq_req   <= qualify;
      ack_valid <= accept;
      if (accept) begin
        ack_vec <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);
        ack_lvl <= win_lvl;
      end
    end
  end

endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
  parameter int N_SRC    = 10,
  parameter int ADDR_W   = 20,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              gie,
  input logic              reti,
  input logic              ack_valid,
  input logic [ADDR_W-1:0] ack_vec,
  input logic [1:0]        ack_lvl,
  input logic [1:0]        cur_lvl,
  input logic              stk_full
);

  localparam logic [ADDR_W-1:0] LAST_VEC = ADDR_W'(VEC_BASE + VEC_STEP * (N_SRC - 1));

  AST_ACK_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ack_lvl > $past(cur_lvl)));  // R7

  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (cur_lvl == ack_lvl));  // R9

  AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (((ack_vec - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STEP)) == '0
                   && ack_vec >= ADDR_W'(VEC_BASE) && ack_vec <= LAST_VEC));  // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    stk_full |=> !ack_valid);  // R11

  AST_RETI_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (reti && cur_lvl != 2'd0) |=> (cur_lvl < $past(cur_lvl)));  // R10

  AST_GIE_GATES: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !ack_valid);  // R4

endmodule

bind irq_level_arbiter irqa_checker #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gie       (gie),
  .reti      (reti),
  .ack_valid (ack_valid),
  .ack_vec   (ack_vec),
  .ack_lvl   (ack_lvl),
  .cur_lvl   (cur_lvl),
  .stk_full  (stk_full)
);

// File: tb/irq_level_arbiter_bench.sv
`timescale 1ns/1ps
module irq_level_arbiter_bench;
  localparam int NS  = 10;
  localparam int DEP = 2;
  localparam int AW  = 20;

  logic clk = 1'b0, rst = 1'b1, gie = 1'b0, take = 1'b0, reti = 1'b0, cfg_we = 1'b0;
  logic [NS-1:0]   en = '0, pend = '0;
  logic [2*NS-1:0] cfg_wd = '0;
  logic            irq_req, ack_valid;
  logic [AW-1:0]   ack_vec;
  logic [1:0]      ack_lvl, cur_lvl;

  always #10 clk = ~clk;

  irq_level_arbiter #(.N_SRC(NS), .STACK_DEPTH(DEP), .ADDR_W(AW)) u_irq_level_arbiter (
    .clk(clk), .rst(rst), .gie(gie), .src_en(en), .src_pend(pend),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wd), .irq_take(take), .reti(reti),
    .irq_req(irq_req), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .ack_lvl(ack_lvl), .cur_lvl(cur_lvl)
  );

  // Behavioural reference
  int    mlvl [NS];
  int    stk [$];
  bit    e_req, e_ack, started;
  int    e_vec, e_lvl;
  string tag = "R1";
  int    compared = 0, mismatched = 0, cyc = 0;

  function automatic int dec(input logic [1:0] c);
    return (c == 2'b00) ? 1 : ((c == 2'b01) ? 2 : 3);
  endfunction

  always @(posedge clk) begin : model
    int best, bl, cur;
    bit q;
    if (rst) begin
      stk.delete();
      foreach (mlvl[i]) mlvl[i] = 1;
      e_req = 0; e_ack = 0; e_vec = 0; e_lvl = 0;
    end else begin
      best = -1; bl = 0;
      for (int i = 0; i < NS; i++)
        if (gie && en[i] && pend[i] && mlvl[i] > bl) begin best = i; bl = mlvl[i]; end
      cur = (stk.size() > 0) ? stk[$] : 0;
      q = (best >= 0) && (bl > cur) && (stk.size() < DEP);
      e_req = q;
      e_ack = 0;
      if (reti) begin
        if (stk.size() > 0) void'(stk.pop_back());
      end else if (take && q) begin
        e_ack = 1; e_vec = 3 + 8 * best; e_lvl = bl; stk.push_back(bl);
      end
      if (cfg_we) for (int i = 0; i < NS; i++) mlvl[i] = dec(cfg_wd[2*i +: 2]);
    end
    started = 1;
  end

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("irq_req", int'(irq_req), int'(e_req));
      check("ack_valid", int'(ack_valid), int'(e_ack));
      if (e_ack) begin
        check("ack_vec", int'(ack_vec), e_vec);
        check("ack_lvl", int'(ack_lvl), e_lvl);
      end
      check("cur_lvl", int'(cur_lvl), (stk.size() > 0) ? stk[$] : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2*NS-1:0] v);
    cfg_wd = v; cfg_we = 1; tick(1); cfg_we = 0;
  endtask

  task automatic drain();
    pend = '0; take = 0; reti = 1; tick(DEP + 1); reti = 0; tick(1);
  endtask

  task automatic fire(input logic [NS-1:0] p, input int n);
    pend = p; take = 1; tick(n); take = 0; tick(2);
  endtask

  initial begin
    tick(3); rst = 0;
    tag = "R1"; tick(3);

    tag = "R3"; // line1 high, line3 top (10), line4 top (11)
    set_cfg(20'b00_00_00_00_00_11_10_00_01_00);
    gie = 1; en = '1;
    fire(10'b00_0001_0010, 1); drain();

    tag = "R4";
    gie = 0; fire('1, 3);
    gie = 1; en = '0; fire('1, 3);
    en = 10'b11_1111_1110; fire(10'b00_0000_0001, 3);
    en = '1; drain();

    tag = "R5"; set_cfg('0); set_cfg(20'b01_00_00_00_00_00_00_00_00_00);
    fire(10'b10_0000_0001, 1); drain();

    tag = "R6"; set_cfg(20'b00_00_00_00_01_00_00_01_00_00);
    fire(10'b00_0010_0101, 1); drain();
    set_cfg(20'b00_00_00_00_00_00_10_00_10_00);
    fire(10'b00_0000_1010, 1); drain();

    tag = "R7"; set_cfg(20'b00_00_00_00_01_00_10_00_01_00);
    fire(10'b00_0000_0010, 1);
    fire(10'b00_0010_0010, 3);
    fire(10'b00_0010_1010, 1);
    drain();

    tag = "R2"; set_cfg('0);
    for (int i = 0; i < NS; i++) begin
      fire(NS'(1) << i, 1);
      reti = 1; tick(1); reti = 0; tick(1);
    end
    drain();

    tag = "R10";
    reti = 1; tick(2); reti = 0; tick(1);
    pend = 10'b00_0000_0001; take = 1; reti = 1; tick(1); reti = 0; take = 0; tick(2);
    drain();

    tag = "R11"; set_cfg(20'b00_00_00_00_00_00_10_00_01_00);
    fire(10'b00_0000_0001, 1);
    fire(10'b00_0000_0011, 1);
    fire(10'b00_0000_1011, 3);
    reti = 1; tick(1); reti = 0;
    fire(10'b00_0000_1011, 1);
    drain();

    tag = "R8";
    for (int k = 0; k < 3000; k++) begin
      gie    = ($urandom % 8) != 0;
      en     = NS'($urandom);
      pend   = NS'($urandom);
      take   = $urandom % 2;
      reti   = ($urandom % 5) == 0;
      cfg_we = ($urandom % 20) == 0;
      cfg_wd = 20'($urandom);
      tick(1);
    end
    cfg_we = 0; take = 0; drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule